// File: doc/BRIEF.md
# Back-Channel Training Burst Sequencer

This block runs a link training session on a parallel transmit lane. While a session is active it alternates PRBS7 bursts with idle gaps on the lane, and it walks through up to three training phases in a fixed order. Responses from the far end move it from phase to phase. Burst and gap durations come from configuration codes and are counted in parallel-word clocks. The defaults correspond to a 32-bit word at 6.4 Gb/s: a gap of 960 ns is 192 clocks, a gap of 1920 ns is 384 clocks, and the longest burst, 81.92 us, is 16384 clocks.

A session begins when the start input rises and lasts as long as start stays high. Four status outputs report on the session: the current phase, a no-response flag raised when the far end stays silent too long, an equalizer-freeze flag raised on entry to coefficient adjustment, and a sticky CRC-error flag with a saturating error count. The error count is fed by pulses from an external packet checker.

Top module: `bc_train_seq`

## Requirements
- R1: After reset the lane is all zeros, lane_burst is 0, stat_phase is 0, and stat_no_resp, stat_eq_freeze, stat_crc_err and stat_crc_cnt are all 0.
- R2: In the cycle after a clock edge that samples cfg_start high while idle, stat_phase is 1 and a burst is on the lane. A clock edge that samples cfg_start low returns to phase 0, zeroes the lane, and clears stat_no_resp, stat_eq_freeze and stat_crc_err.
- R3: Each gap lasts GAP_SHORT clocks when cfg_gap_long is 0 and GAP_LONG clocks when it is 1 (defaults 192 and 384).
- R4: With cfg_fixed_len set, every burst lasts BURST_MAX >> (3 - cfg_pat_code) clocks. Codes 0, 1, 2 and 3 give 1/8, 1/4, 1/2 and all of BURST_MAX.
- R5: With cfg_fixed_len clear, the first burst of a session lasts BURST_MAX/8 clocks and each later burst is twice the previous one, capped at BURST_MAX.
- R6: Burst data is PRBS7 with polynomial x^7+x^6+1. The state is set to all ones at session start. Each step computes b = s[6]^s[5] and shifts s = {s[5:0], b}. Bit i of a lane word is the b of step i+1, counted from the state at the start of that word. The state advances only during bursts, and the lane is zero during gaps.
- R7: Phase codes are 0 idle, 1 recognition, 2 power adjust and 3 coefficient adjust. A response pulse in phase 1 moves to phase 2, or to phase 3 when cfg_skip_power is 1. A response pulse in phase 2 moves to phase 3.
- R8: If TIMEOUT burst/gap periods complete in phase 1 with no response, stat_no_resp is set. Phase 1 persists and bursts continue. A later response clears the flag.
- R9: stat_eq_freeze is set in the cycle in which phase 3 is entered, and it is cleared by the next response pulse in phase 3.
- R10: While cfg_chan_en is 0, far_resp and crc_fail pulses have no effect.
- R11: Each crc_fail pulse during a session sets stat_crc_err and adds one to stat_crc_cnt. The count saturates at its maximum and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start | input | 1 | Session start, held high for the session |
| cfg_gap_long | input | 1 | Gap length select |
| cfg_fixed_len | input | 1 | Fixed burst length enable |
| cfg_pat_code | input | 2 | Burst length code |
| cfg_skip_power | input | 1 | Skip the power-adjust phase |
| cfg_chan_en | input | 1 | Accept far-end responses and CRC reports |
| far_resp | input | 1 | One-cycle far-end response pulse |
| crc_fail | input | 1 | One-cycle CRC failure pulse |
| lane_data | output | WORD_W | Lane word, PRBS7 in bursts, zero otherwise |
| lane_burst | output | 1 | High while a burst is on the lane |
| stat_phase | output | 2 | Current phase code |
| stat_no_resp | output | 1 | Far end silent past the timeout |
| stat_eq_freeze | output | 1 | Equalizer freeze status |
| stat_crc_err | output | 1 | Sticky CRC error flag |
| stat_crc_cnt | output | CRC_W | Saturating CRC error count |

## Verification
A wrong duration counter shows up as a burst or gap run of the wrong length on lane_burst, and it does so within the first period after start, or within the first few bursts for the doubling case. A wrong PRBS seed or stepping corrupts the very first lane word of a session. A wrong phase or flag register shows up on the status outputs one clock after the response or CRC pulse that should have moved it. A wrong timeout count moves the rise of stat_no_resp by at least a whole period.

// File: rtl/bc_train_seq.sv
module bc_train_seq #(
  parameter int WORD_W    = 32,
  parameter int GAP_SHORT = 192,
  parameter int GAP_LONG  = 384,
  parameter int BURST_MAX = 16384,
  parameter int TIMEOUT   = 16,
  parameter int CRC_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic              cfg_gap_long,
  input  logic              cfg_fixed_len,
  input  logic [1:0]        cfg_pat_code,
  input  logic              cfg_skip_power,
  input  logic              cfg_chan_en,
  input  logic              far_resp,
  input  logic              crc_fail,
  output logic [WORD_W-1:0] lane_data,
  output logic              lane_burst,
  output logic [1:0]        stat_phase,
  output logic              stat_no_resp,
  output logic              stat_eq_freeze,
  output logic              stat_crc_err,
  output logic [CRC_W-1:0]  stat_crc_cnt
);
  localparam int LMAX = (BURST_MAX > GAP_LONG) ? BURST_MAX : GAP_LONG;
  localparam int TW   = $clog2(LMAX) + 1;
  localparam int PW   = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_RECOG = 2'd1, PH_POWER = 2'd2, PH_COEFF = 2'd3} phase_t;

  phase_t            phase_q;
  logic              in_burst_q, no_resp_q, freeze_q, crc_err_q;
  logic [TW-1:0]     tcnt_q, blen, glen;
  logic [6:0]        lfsr_q, lfsr_nx;
  logic [1:0]        sh_q, sel;
  logic [PW-1:0]     pcnt_q;
  logic [CRC_W-1:0]  crc_cnt_q;
  logic [WORD_W-1:0] word;
  logic              resp_ok;

  assign resp_ok = far_resp && cfg_chan_en;
  assign sel     = cfg_fixed_len ? cfg_pat_code : sh_q;
  assign blen    = TW'(BURST_MAX) >> (2'd3 - sel);
  assign glen    = cfg_gap_long ? TW'(GAP_LONG) : TW'(GAP_SHORT);

  always_comb begin
    logic [6:0] s;
    s    = lfsr_q;
    word = '0;
    for (int i = 0; i < WORD_W; i++) begin
      s       = {s[5:0], s[6] ^ s[5]};
      word[i] = s[0];
    end
    lfsr_nx = s;
  end

  assign lane_data      = in_burst_q ? word : '0;
  assign lane_burst     = in_burst_q;
  assign stat_phase     = phase_q;
  assign stat_no_resp   = no_resp_q;
  assign stat_eq_freeze = freeze_q;
  assign stat_crc_err   = crc_err_q;
  assign stat_crc_cnt   = crc_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      in_burst_q <= 1'b0;
      tcnt_q     <= '0;
      lfsr_q     <= 7'h7F;
      sh_q       <= 2'd0;
      pcnt_q     <= '0;
      no_resp_q  <= 1'b0;
      freeze_q   <= 1'b0;
    end else if (!cfg_start) begin
      phase_q    <= PH_IDLE;
      in_burst_q <= 1'b0;
      tcnt_q     <= '0;
      sh_q       <= 2'd0;
      pcnt_q     <= '0;
      no_resp_q  <= 1'b0;
      freeze_q   <= 1'b0;
    end else if (phase_q == PH_IDLE) begin
      phase_q    <= PH_RECOG;
      in_burst_q <= 1'b1;
      tcnt_q     <= blen - TW'(1);
      lfsr_q     <= 7'h7F;
    end else begin
      if (in_burst_q) begin
        lfsr_q <= lfsr_nx;
        if (tcnt_q == '0) begin
          in_burst_q <= 1'b0;
          tcnt_q     <= glen - TW'(1);
          if (!cfg_fixed_len && sh_q != 2'd3) sh_q <= sh_q + 2'd1;
        end else begin
          tcnt_q <= tcnt_q - TW'(1);
        end
      end else if (tcnt_q == '0) begin
        in_burst_q <= 1'b1;
        tcnt_q     <= blen - TW'(1);
        if (phase_q == PH_RECOG) begin
          if (pcnt_q == PW'(TIMEOUT - 1)) no_resp_q <= 1'b1;
          else pcnt_q <= pcnt_q + PW'(1);
        end
      end else begin
        tcnt_q <= tcnt_q - TW'(1);
      end
      if (resp_ok) begin
        case (phase_q)
          PH_RECOG: begin
            phase_q   <= cfg_skip_power ? PH_COEFF : PH_POWER;
            freeze_q  <= cfg_skip_power;
            no_resp_q <= 1'b0;
            pcnt_q    <= '0;
          end
          PH_POWER: begin
            phase_q  <= PH_COEFF;
            freeze_q <= 1'b1;
          end
          PH_COEFF: freeze_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_cnt_q <= '0;
      crc_err_q <= 1'b0;
    end else if (!cfg_start) begin
      crc_err_q <= 1'b0;
    end else if (crc_fail && cfg_chan_en && phase_q != PH_IDLE) begin
      crc_err_q <= 1'b1;
      if (!(&crc_cnt_q)) crc_cnt_q <= crc_cnt_q + CRC_W'(1);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> !in_burst_q); // R2
  AST_PHASE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q) && phase_q != PH_IDLE) |-> (phase_q > $past(phase_q))); // R7
  AST_NORESP_IN_RECOG: assert property (@(posedge clk) disable iff (!rst_n)
    no_resp_q |-> (phase_q == PH_RECOG)); // R8
  AST_FREEZE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_COEFF && $past(phase_q) != PH_COEFF) |-> freeze_q); // R9
  AST_CRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_cnt_q != $past(crc_cnt_q)) |-> (crc_cnt_q == $past(crc_cnt_q) + CRC_W'(1))); // R11
endmodule

// File: tb/bc_train_seq_tb.sv
module bc_train_seq_tb_top;
  localparam int WW = 32;
  localparam int GS = 6, GL = 12, BM = 32, TO = 4, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_start = 0, cfg_gap_long = 0, cfg_fixed_len = 1, cfg_skip_power = 0, cfg_chan_en = 1;
  logic [1:0] cfg_pat_code = 2'd0;
  logic far_resp = 0, crc_fail = 0;
  logic [WW-1:0] lane_data;
  logic lane_burst, stat_no_resp, stat_eq_freeze, stat_crc_err;
  logic [1:0] stat_phase;
  logic [CW-1:0] stat_crc_cnt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bc_train_seq #(.WORD_W(WW), .GAP_SHORT(GS), .GAP_LONG(GL), .BURST_MAX(BM),
                 .TIMEOUT(TO), .CRC_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_gap_long(cfg_gap_long),
    .cfg_fixed_len(cfg_fixed_len), .cfg_pat_code(cfg_pat_code), .cfg_skip_power(cfg_skip_power),
    .cfg_chan_en(cfg_chan_en), .far_resp(far_resp), .crc_fail(crc_fail),
    .lane_data(lane_data), .lane_burst(lane_burst), .stat_phase(stat_phase),
    .stat_no_resp(stat_no_resp), .stat_eq_freeze(stat_eq_freeze),
    .stat_crc_err(stat_crc_err), .stat_crc_cnt(stat_crc_cnt));

  localparam int NV = 4;
  localparam int V_CODE [NV] = '{0, 1, 2, 3};
  localparam int V_GAPL [NV] = '{0, 1, 0, 1};
  localparam int V_BURST[NV] = '{4, 8, 16, 32};
  localparam int V_GAP  [NV] = '{6, 12, 6, 12};

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_len(input logic val, output int n);
    n = 0;
    while (lane_burst == val && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic pulse_resp();
    far_resp = 1; @(negedge clk); far_resp = 0;
  endtask

  task automatic pulse_crc();
    crc_fail = 1; @(negedge clk); crc_fail = 0;
  endtask

  task automatic restart();
    cfg_start = 0; @(negedge clk);
    cfg_start = 1; @(negedge clk);
  endtask

  function automatic logic [WW-1:0] prbs_word(input int idx);
    logic [6:0] s = 7'h7F;
    logic [WW-1:0] w = '0;
    for (int k = 0; k <= idx; k++)
      for (int i = 0; i < WW; i++) begin
        logic b;
        b = s[6] ^ s[5];
        s = {s[5:0], b};
        w[i] = b;
      end
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 lane", lane_data, 0);
    check("R1 phase", stat_phase, 0);
    check("R1 no_resp", stat_no_resp, 0);
    check("R1 freeze", stat_eq_freeze, 0);
    check("R1 crc", {stat_crc_err, stat_crc_cnt}, 0);
    rst_n = 1; @(negedge clk);

    // R3 R4: table of fixed-length codes and gap selections
    for (int v = 0; v < NV; v++) begin
      cfg_fixed_len = 1; cfg_pat_code = 2'(V_CODE[v]); cfg_gap_long = V_GAPL[v][0];
      restart();
      check("R2 phase after start", stat_phase, 1);
      run_len(1'b1, n); check("R4 burst length", n, V_BURST[v]);
      run_len(1'b0, n); check("R3 gap length", n, V_GAP[v]);
    end

    // R6: PRBS content and quiet gaps
    cfg_pat_code = 2'd0; cfg_gap_long = 0;
    restart();
    check("R6 word0", lane_data, prbs_word(0)); @(negedge clk);
    check("R6 word1", lane_data, prbs_word(1));
    repeat (3) @(negedge clk);
    check("R6 gap zero", lane_data, 0);
    repeat (6) @(negedge clk);
    check("R6 word4 after gap", lane_data, prbs_word(4));

    // R5: doubling burst lengths
    cfg_fixed_len = 0;
    restart();
    for (int b = 0; b < 5; b++) begin
      run_len(1'b1, n); check("R5 doubling burst", n, (b < 3) ? (4 << b) : 32);
      run_len(1'b0, n);
    end

    // R8 R10: silent far end
    cfg_fixed_len = 1; cfg_pat_code = 2'd0; cfg_chan_en = 0; cfg_skip_power = 0;
    restart();
    pulse_resp();
    check("R10 resp ignored", stat_phase, 1);
    repeat (33) @(negedge clk);
    check("R8 no_resp before timeout", stat_no_resp, 0);
    repeat (10) @(negedge clk);
    check("R8 no_resp set", stat_no_resp, 1);
    check("R8 still recognition", stat_phase, 1);
    n = 0;
    repeat (20) begin @(negedge clk); if (lane_burst) n++; end
    check("R8 bursts continue", n, 8);
    pulse_crc();
    check("R10 crc ignored", {stat_crc_err, stat_crc_cnt}, 0);

    // R7 R9: phase walk
    cfg_chan_en = 1;
    pulse_resp();
    check("R7 to power", stat_phase, 2);
    check("R8 no_resp cleared", stat_no_resp, 0);
    check("R9 freeze low in power", stat_eq_freeze, 0);
    pulse_resp();
    check("R7 to coeff", stat_phase, 3);
    check("R9 freeze on entry", stat_eq_freeze, 1);
    pulse_resp();
    check("R9 freeze cleared", stat_eq_freeze, 0);
    check("R7 coeff holds", stat_phase, 3);

    // R7 skip, R11 crc
    cfg_skip_power = 1;
    restart();
    pulse_resp();
    check("R7 skip to coeff", stat_phase, 3);
    check("R9 freeze on skip entry", stat_eq_freeze, 1);
    repeat (3) pulse_crc();
    check("R11 crc count", stat_crc_cnt, 3);
    check("R11 crc flag", stat_crc_err, 1);
    cfg_chan_en = 0; pulse_crc(); cfg_chan_en = 1;
    check("R10 crc ignored in session", stat_crc_cnt, 3);
    repeat (6) pulse_crc();
    check("R11 crc saturates", stat_crc_cnt, 7);

    // R2: stop
    cfg_start = 0; @(negedge clk);
    check("R2 idle phase", stat_phase, 0);
    check("R2 lane zero", {lane_burst, lane_data}, 0);
    check("R2 flags cleared", {stat_crc_err, stat_eq_freeze, stat_no_resp}, 0);
    check("R11 count kept", stat_crc_cnt, 7);
    pulse_resp();
    check("R7 resp ignored in idle", stat_phase, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule